// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a 32,768 Hz oscillator enable into a one-cycle pulse per second. The division is done in two stages: a block counter of `LOW_DIV` enables (256 by default) and a count of `HIGH_DIV` such blocks (128 by default). The frequency is trimmed digitally, not by changing the divide ratio. Over a schedule of `MIN_PER_CYCLE` minutes (64 by default), the first second of selected minutes is shortened by one whole block or lengthened by half a block. The number of affected minutes is twice the calibration magnitude, capped at `MOD_LIMIT` (62).

A stop input freezes every counter without clearing it. A frequency-test mode replaces the seconds parity output with a fixed square wave. That square wave is derived from the raw enable count, so calibration never moves it. The block has no data stream, so every pin is a plain control or status signal.

Top module: `cal_prescaler`

## Requirements
- R1: With calibration magnitude 0 and either sign, every second lasts exactly `LOW_DIV*HIGH_DIV` counted enables; the same holds for every second not selected by R2/R3.
- R2: With sign 1 and magnitude N>0, the first second (index 0) of each minute with index below min(2N, `MOD_LIMIT`) lasts `(HIGH_DIV-1)*LOW_DIV` enables.
- R3: With sign 0 and magnitude N>0, the first second of each such minute lasts `LOW_DIV*HIGH_DIV + LOW_DIV/2` enables.
- R4: Minute indices run from 0 to `MIN_PER_CYCLE-1` and then wrap. Minutes at or above `MOD_LIMIT` are never modified, and the schedule repeats identically in every cycle.
- R5: `min_mark` is high for one cycle, together with `sec_tick`, exactly when the ending second has index `SEC_PER_MIN-1`.
- R6: While `stop` is 1, no enable is counted and no tick occurs. After `stop` returns to 0, counting resumes from the held state.
- R7: Only cycles with `osc_en`=1 and `stop`=0 advance the counters. A tick appears in the cycle after the advance that ends a second.
- R8: With `ftest_en`=1, `out_wave` toggles every `TEST_HALF` counted enables whatever the calibration inputs, and holds on cycles that count nothing.
- R9: With `ftest_en`=0, `out_wave` is the seconds parity: it toggles in the same cycle as each `sec_tick` and at no other time.
- R10: After reset, `sec_tick`, `min_mark` and `out_wave` are 0. The first second starts at minute 0, second 0.
- R11: `sec_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| stop | input | 1 | Freeze all counters while 1 |
| cal_mag | input | CAL_W | Calibration magnitude N |
| cal_sign | input | 1 | 1 = speed up (shorten), 0 = slow down (lengthen) |
| ftest_en | input | 1 | Select test square wave on out_wave |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |
| min_mark | output | 1 | One-cycle pulse at each minute boundary |
| out_wave | output | 1 | Seconds parity, or test square wave |

## Verification
A wrong block or block-count terminal shows up in the first second as a wrong number of enables between ticks. A wrong minute or cycle index only shows when the corrected second lands in the wrong minute, or is missing. That can take up to a full correction cycle, so each calibration setting is run over at least one complete schedule, and one setting over two. A test-wave counter that is wrong, or that depends on calibration, shows up within one half period of `out_wave`.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_SHORT = 2'd1,
    CORR_LONG  = 2'd2
  } corr_e;

  function automatic int unsigned cap_minutes(int unsigned want, int unsigned cap);
    return (want > cap) ? cap : want;
  endfunction

endpackage

// File: rtl/cps_schedule.sv
module cps_schedule import cps_pkg::*; #(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int MOD_LIMIT     = 62,
  parameter int CAL_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_end,
  input  logic [CAL_W-1:0] cal_mag,
  input  logic             cal_sign,
  output corr_e            corr,
  output logic             last_sec
);
  localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MW = (MIN_PER_CYCLE > 1) ? $clog2(MIN_PER_CYCLE) : 1;
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(MIN_PER_CYCLE - 1);

  logic [SW-1:0] sec_idx;
  logic [MW-1:0] min_idx;
  int unsigned   mod_minutes;
  logic          selected;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_idx <= '0;
      min_idx <= '0;
    end else if (sec_end) begin
      if (sec_idx == SEC_LAST) begin
        sec_idx <= '0;
        min_idx <= (min_idx == MIN_LAST) ? '0 : min_idx + 1'b1;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  always_comb begin
    mod_minutes = cap_minutes(32'(cal_mag) << 1, MOD_LIMIT);
    selected    = (sec_idx == '0) && (32'(min_idx) < mod_minutes);
    if (!selected)     corr = CORR_NONE;
    else if (cal_sign) corr = CORR_SHORT;
    else               corr = CORR_LONG;
  end

  assign last_sec = (sec_idx == SEC_LAST);

endmodule

// File: rtl/cps_divider.sv
module cps_divider import cps_pkg::*; #(
  parameter int LOW_DIV  = 256,
  parameter int HIGH_DIV = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  corr_e corr,
  output logic  sec_end
);
  localparam int LONG_LEN = LOW_DIV + LOW_DIV / 2;
  localparam int LW = $clog2(LONG_LEN);
  localparam int HW = (HIGH_DIV > 1) ? $clog2(HIGH_DIV) : 1;
  localparam logic [LW-1:0] LOW_NORM_LAST = LW'(LOW_DIV - 1);
  localparam logic [LW-1:0] LOW_LONG_LAST = LW'(LONG_LEN - 1);
  localparam logic [HW-1:0] HIGH_NORM_LAST  = HW'(HIGH_DIV - 1);
  localparam logic [HW-1:0] HIGH_SHORT_LAST = HW'(HIGH_DIV - 2);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic [LW-1:0] low_last;
  logic [HW-1:0] high_last;
  logic          blk_end;

  always_comb begin
    low_last  = (corr == CORR_LONG && high_cnt == HIGH_NORM_LAST) ? LOW_LONG_LAST
                                                                  : LOW_NORM_LAST;
    high_last = (corr == CORR_SHORT) ? HIGH_SHORT_LAST : HIGH_NORM_LAST;
    blk_end   = adv && (low_cnt >= low_last);
    sec_end   = blk_end && (high_cnt >= high_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else if (adv) begin
      if (blk_end) begin
        low_cnt  <= '0;
        high_cnt <= sec_end ? '0 : high_cnt + 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cps_testwave.sv
module cps_testwave #(
  parameter int TEST_HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic square
);
  generate
    if (TEST_HALF <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)   square <= 1'b0;
        else if (adv) square <= ~square;
      end
    end else begin : g_count
      localparam int TW = $clog2(TEST_HALF);
      localparam logic [TW-1:0] T_LAST = TW'(TEST_HALF - 1);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tcnt   <= '0;
          square <= 1'b0;
        end else if (adv) begin
          if (tcnt == T_LAST) begin
            tcnt   <= '0;
            square <= ~square;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler import cps_pkg::*; #(
  parameter int LOW_DIV       = 256,
  parameter int HIGH_DIV      = 128,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int MOD_LIMIT     = 62,
  parameter int TEST_HALF     = 32,
  parameter int CAL_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop,
  input  logic [CAL_W-1:0] cal_mag,
  input  logic             cal_sign,
  input  logic             ftest_en,
  output logic             sec_tick,
  output logic             min_mark,
  output logic             out_wave
);
  logic  adv;
  logic  sec_end;
  logic  last_sec;
  logic  sec_lsb;
  logic  tw_sq;
  corr_e corr;

  assign adv = osc_en & ~stop;

  cps_schedule #(
    .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE),
    .MOD_LIMIT(MOD_LIMIT), .CAL_W(CAL_W)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .sec_end(sec_end),
    .cal_mag(cal_mag), .cal_sign(cal_sign),
    .corr(corr), .last_sec(last_sec)
  );

  cps_divider #(.LOW_DIV(LOW_DIV), .HIGH_DIV(HIGH_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .adv(adv), .corr(corr), .sec_end(sec_end)
  );

  cps_testwave #(.TEST_HALF(TEST_HALF)) u_tw (
    .clk(clk), .rst_n(rst_n), .adv(adv), .square(tw_sq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_tick <= 1'b0;
      min_mark <= 1'b0;
      sec_lsb  <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      min_mark <= sec_end & last_sec;
      if (sec_end) sec_lsb <= ~sec_lsb;
    end
  end

  assign out_wave = ftest_en ? tw_sq : sec_lsb;

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int LOW_DIV  = 256,
  parameter int HIGH_DIV = 128
) (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic stop,
  input logic ftest_en,
  input logic sec_tick,
  input logic min_mark,
  input logic out_wave
);
  localparam int MAX_LEN = LOW_DIV * HIGH_DIV + LOW_DIV / 2;
  localparam int MIN_LEN = LOW_DIV * (HIGH_DIV - 1);

  int adv_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        adv_cnt <= 0;
    else if (sec_tick) adv_cnt <= (osc_en && !stop) ? 1 : 0;
    else if (osc_en && !stop) adv_cnt <= adv_cnt + 1;
  end

  a_r11_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r5_mark_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    min_mark |-> sec_tick);

  a_r6_no_tick_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop || !osc_en) |-> !sec_tick);

  a_r3_len_max: assert property (@(posedge clk) disable iff (!rst_n)
    adv_cnt <= MAX_LEN);

  a_r2_len_min: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> adv_cnt >= MIN_LEN);

  a_r8_wave_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ftest_en && $past(ftest_en) && $past(stop || !osc_en)) |-> $stable(out_wave));

  a_r9_parity_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!ftest_en && $past(!ftest_en)) |-> ((out_wave != $past(out_wave)) == sec_tick));

endmodule

bind cal_prescaler cps_checker #(.LOW_DIV(LOW_DIV), .HIGH_DIV(HIGH_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .ftest_en(ftest_en),
  .sec_tick(sec_tick), .min_mark(min_mark), .out_wave(out_wave)
);

// File: tb/cal_prescaler_test.sv
module cal_prescaler_test;
  localparam int LOW_DIV = 8;
  localparam int HIGH_DIV = 4;
  localparam int SPM = 3;
  localparam int MPC = 8;
  localparam int MODL = 6;
  localparam int THALF = 2;
  localparam int NORM = LOW_DIV * HIGH_DIV;
  localparam int SECS = SPM * MPC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0;
  logic stop = 1'b0;
  logic [4:0] cal_mag = '0;
  logic cal_sign = 1'b0;
  logic ftest_en = 1'b0;
  logic sec_tick, min_mark, out_wave;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int run_cnt = 0;
  int gap_mode = 0;
  int stop_from = -1;
  int stop_to = -1;
  int double_tick = 0;
  int blocked_tick = 0;
  logic prev_tick = 1'b0;
  logic prev_wave = 1'b0;
  logic prev_blocked = 1'b0;

  always #10 clk = ~clk;

  cal_prescaler #(
    .LOW_DIV(LOW_DIV), .HIGH_DIV(HIGH_DIV), .SEC_PER_MIN(SPM),
    .MIN_PER_CYCLE(MPC), .MOD_LIMIT(MODL), .TEST_HALF(THALF), .CAL_W(5)
  ) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
    .cal_mag(cal_mag), .cal_sign(cal_sign), .ftest_en(ftest_en),
    .sec_tick(sec_tick), .min_mark(min_mark), .out_wave(out_wave)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(int k, int mag, int sgn);
    int s = k % SPM;
    int m = (k / SPM) % MPC;
    int lim = (2 * mag > MODL) ? MODL : 2 * mag;
    if (mag != 0 && s == 0 && m < lim) return sgn ? NORM - LOW_DIV : NORM + LOW_DIV / 2;
    return NORM;
  endfunction

  function automatic string len_tag(int k, int mag, int sgn);
    int m = (k / SPM) % MPC;
    if (mag == 0) return "R1";
    if (exp_len(k, mag, sgn) != NORM) return sgn ? "R2" : "R3";
    if (m >= MODL) return "R4";
    return "R1";
  endfunction

  task automatic do_reset(input int mag, input int sgn, input bit ft);
    rst_n = 1'b0;
    cal_mag = 5'(mag);
    cal_sign = sgn[0];
    ftest_en = ft;
    osc_en = 1'b1;
    stop = 1'b0;
    repeat (3) @(negedge clk);
    check(!sec_tick && !min_mark && !out_wave, "R10 reset outputs",
          {29'd0, sec_tick, min_mark, out_wave}, 0);
    rst_n = 1'b1;
    cyc = 0;
    run_cnt = 1;
    prev_tick = 1'b0;
    prev_wave = 1'b0;
    prev_blocked = 1'b0;
  endtask

  task automatic wait_evt(input bit wave_mode, output int len, output logic mm);
    int guard = 0;
    len = -1;
    mm = 1'b0;
    while (len < 0 && guard < 4000) begin
      @(negedge clk);
      cyc++;
      guard++;
      if (sec_tick && prev_tick) double_tick++;
      if (sec_tick && prev_blocked) blocked_tick++;
      prev_tick = sec_tick;
      if (wave_mode ? (out_wave != prev_wave) : sec_tick) begin
        len = run_cnt;
        mm = min_mark;
        run_cnt = 0;
      end
      prev_wave = out_wave;
      osc_en = (gap_mode <= 1) ? 1'b1 : ((cyc % gap_mode) == 0);
      stop = (cyc >= stop_from && cyc < stop_to);
      prev_blocked = !(osc_en && !stop);
      if (!prev_blocked) run_cnt++;
    end
    if (len < 0) check(1'b0, "R7 event timeout", guard, 0);
  endtask

  task automatic run_seconds(input int mag, input int sgn, input int nsec);
    int len;
    logic mm;
    for (int k = 0; k < nsec; k++) begin
      wait_evt(1'b0, len, mm);
      check(len == exp_len(k, mag, sgn), len_tag(k, mag, sgn), len, exp_len(k, mag, sgn));
      check(mm == ((k % SPM) == SPM - 1), "R5 minute marker", int'(mm), int'((k % SPM) == SPM - 1));
      check(out_wave == ((k + 1) % 2 == 1), "R9 seconds parity", int'(out_wave), (k + 1) % 2);
    end
  endtask

  initial begin
    int len;
    logic mm;
    int t0;

    // R1 R2 R3 R4 R5 R9: sweep all magnitudes and both signs over a full schedule
    for (int sg = 0; sg < 2; sg++) begin
      for (int mag = 0; mag < 32; mag++) begin
        do_reset(mag, sg, 1'b0);
        run_seconds(mag, sg, (mag == 31) ? 2 * SECS : SECS);
      end
    end

    // R7: sparse oscillator enables, counting only enabled cycles
    gap_mode = 3;
    do_reset(5, 1, 1'b0);
    run_seconds(5, 1, SECS);
    gap_mode = 0;

    // R6: stop window inside the second second of the schedule
    do_reset(2, 0, 1'b0);
    stop_from = 50;
    stop_to = 150;
    wait_evt(1'b0, len, mm);
    check(len == exp_len(0, 2, 0), "R3 first second before stop", len, exp_len(0, 2, 0));
    t0 = cyc;
    wait_evt(1'b0, len, mm);
    check(len == NORM, "R6 enables across stop", len, NORM);
    check(cyc - t0 == NORM + 100, "R6 frozen duration", cyc - t0, NORM + 100);
    wait_evt(1'b0, len, mm);
    check(len == NORM && mm, "R6 resumed second with marker", len, NORM);
    stop_from = -1;
    stop_to = -1;

    // R8: test square wave independent of calibration
    for (int c = 0; c < 3; c++) begin
      do_reset((c == 0) ? 0 : 31, (c == 1) ? 1 : 0, 1'b1);
      for (int e = 0; e < 16; e++) begin
        wait_evt(1'b1, len, mm);
        check(len == THALF, "R8 test half period", len, THALF);
      end
    end
    gap_mode = 2;
    do_reset(31, 1, 1'b1);
    for (int e = 0; e < 8; e++) begin
      wait_evt(1'b1, len, mm);
      check(len == THALF, "R8 test half period with gaps", len, THALF);
    end
    gap_mode = 0;

    check(double_tick == 0, "R11 tick width", double_tick, 0);
    check(blocked_tick == 0, "R7 tick only after an advance", blocked_tick, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule